// File: doc/BRIEF.md
# Receive FIFO Trigger and Interrupt Identification Controller

This block is the receive half of a 16550-style serial port. It takes finished bytes from a deserializer and queues them. It raises an interrupt when software should empty the queue, and it reports the reason through an identification register. The queue runs in one of three configurations: a one-byte holding register when FIFOs are disabled, a 16-entry FIFO, or an extended 64-entry FIFO. The 64-entry mode is selected at run time, and each depth has its own table of receive trigger points.

Software uses a small register port. A read of the data address pops the oldest byte. A write to the control address selects the enable, the depth and the trigger point, and can flush the queue. A read of that same address returns the identification register. A read of the status address returns data-ready and a sticky overrun flag, and the read clears the flag. A one-cycle `char_tick` pulse per character time comes from the baud logic outside the block and drives the character timeout.

Top module: `uart_rx_fifo_ctrl`

## Requirements
- R1: With the FIFO enabled and 64-entry mode off, control bits 7:6 pick a receive trigger of 1, 4, 8 or 14 bytes for the codes 00, 01, 10 and 11.
- R2: When control bit 5 is set (64-entry mode) with the FIFO enabled, the same codes pick 1, 16, 32 or 56 bytes.
- R3: The received-data interrupt is pending while the fill count is at or above the trigger. It stops being pending as soon as reads take the count below the trigger.
- R4: Identification register layout: bit 0 is 0 when any source is pending and 1 otherwise. Bits 3:1 carry the source code: 011 line status, 010 received data, 110 character timeout, 000 none. Bits 7:6 read 11 when the FIFO is enabled (control bit 0) and 00 when it is not. Bit 5 reads 1 only when the FIFO is enabled in 64-entry mode. Bit 4 reads 0.
- R5: Priority is overrun (line status) first, then received data, then character timeout. The identification code always shows the highest pending source.
- R6: A character timeout becomes pending after 4 `char_tick` pulses with no byte received and no data read, while the queue holds more than 0 and fewer than trigger bytes. A receive or a data read clears it.
- R7: Capacity is 16 or 64 entries. A byte that arrives while the queue is full and no pop happens in that cycle is dropped and sets the overrun flag (status bit 1). The flag stays set until a status read.
- R8: Writing control bit 1, or changing the enable bit or the 64-entry bit, empties the queue. Status bit 0 (data ready) then reads 0.
- R9: Data reads return bytes in arrival order. A data read of an empty queue returns 0 and changes nothing.
- R10: `irq` is high exactly when the identification register reports a pending source.
- R11: With control bit 0 clear, the queue holds one byte with a trigger of 1. A second unread byte causes an overrun.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | A received byte is presented this cycle |
| rx_data | input | 8 | Received byte |
| char_tick | input | 1 | One pulse per character time |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (data and status reads have side effects) |
| reg_addr | input | 3 | Register address: 0 data, 2 control/identification, 5 status |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, combinational from current state and address |
| irq | output | 1 | Interrupt request |

## Verification
`reg_rdata` and `irq` are combinational from registered state, so each result reflects every edge before it. A byte pushed, a pop or a control write at one rising edge is visible on a read issued in the following cycle. The bench drives inputs just after a falling edge and samples one time unit later, before the next rising edge. It then advances its reference queue, overrun flag and idle-tick counter at that rising edge, so every comparison uses the state left by the edges already taken. The timeout is checked on the cycle after the fourth idle tick has been clocked in, because that is the first cycle in which it can be visible.

// File: rtl/uart_rxq_pkg.sv
package uart_rxq_pkg;

    localparam int DATA_W      = 8;
    localparam int BIG_DEPTH   = 64;
    localparam int SMALL_DEPTH = 16;
    localparam int CNT_W       = $clog2(BIG_DEPTH + 1);
    localparam int PTR_W       = $clog2(BIG_DEPTH);
    localparam int IDLE_CHARS  = 4;

    localparam logic [2:0] ADDR_DATA = 3'd0;
    localparam logic [2:0] ADDR_CTRL = 3'd2;
    localparam logic [2:0] ADDR_STAT = 3'd5;

    typedef struct packed {
        logic [1:0] trig;
        logic       wide;
        logic       en;
    } rxq_cfg_t;

    typedef enum logic [2:0] {
        SRC_NONE = 3'b000,
        SRC_LINE = 3'b011,
        SRC_DATA = 3'b010,
        SRC_IDLE = 3'b110
    } irq_src_e;

    function automatic logic [CNT_W-1:0] rxq_capacity(rxq_cfg_t c);
        if (!c.en)       return CNT_W'(1);
        else if (c.wide) return CNT_W'(BIG_DEPTH);
        else             return CNT_W'(SMALL_DEPTH);
    endfunction

    function automatic logic [CNT_W-1:0] rxq_trigger(rxq_cfg_t c);
        logic [CNT_W-1:0] lvl;
        if (!c.en) begin
            lvl = CNT_W'(1);
        end else if (c.wide) begin
            case (c.trig)
                2'b00:   lvl = CNT_W'(1);
                2'b01:   lvl = CNT_W'(16);
                2'b10:   lvl = CNT_W'(32);
                default: lvl = CNT_W'(56);
            endcase
        end else begin
            case (c.trig)
                2'b00:   lvl = CNT_W'(1);
                2'b01:   lvl = CNT_W'(4);
                2'b10:   lvl = CNT_W'(8);
                default: lvl = CNT_W'(14);
            endcase
        end
        return lvl;
    endfunction

endpackage

// File: rtl/rxq_store.sv
module rxq_store
    import uart_rxq_pkg::*;
#(
    parameter int DEPTH = BIG_DEPTH,
    parameter int DW    = DATA_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic             pop,
    input  logic             flush,
    input  logic [DW-1:0]    din,
    input  logic [CNT_W-1:0] cap,
    output logic [DW-1:0]    dout,
    output logic [CNT_W-1:0] count,
    output logic             dropped
);
    localparam int PW = $clog2(DEPTH);

    logic [DW-1:0] mem [DEPTH];
    logic [PW-1:0] wr_ptr, rd_ptr;
    logic          do_push, do_pop;

    assign do_pop  = pop && (count != '0);
    assign do_push = push && ((count < cap) || do_pop);
    assign dropped = push && !do_push && !flush;
    assign dout    = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (do_push && !flush)
            mem[wr_ptr] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= wr_ptr + PW'(1);
            if (do_pop)  rd_ptr <= rd_ptr + PW'(1);
            case ({do_push, do_pop})
                2'b10:   count <= count + CNT_W'(1);
                2'b01:   count <= count - CNT_W'(1);
                default: count <= count;
            endcase
        end
    end

    // R7
    fill_bound_chk: assert property (@(posedge clk) disable iff (rst)
        count <= cap);

    // R7
    drop_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (push && !pop && !flush && count == cap) |=> count == $past(count));

    // R8
    flush_empty_chk: assert property (@(posedge clk) disable iff (rst)
        flush |=> count == '0);

endmodule

// File: rtl/rxq_idle_timer.sv
module rxq_idle_timer
    import uart_rxq_pkg::*;
#(
    parameter int TICKS = IDLE_CHARS
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             activity,
    input  logic             tick,
    input  logic [CNT_W-1:0] count,
    input  logic [CNT_W-1:0] trig,
    output logic             pend
);
    localparam int TW = $clog2(TICKS + 1);

    logic [TW-1:0] ticks_q;

    always_ff @(posedge clk) begin
        if (rst || activity || count == '0)
            ticks_q <= '0;
        else if (tick && ticks_q != TW'(TICKS))
            ticks_q <= ticks_q + TW'(1);
    end

    assign pend = (ticks_q == TW'(TICKS)) && (count != '0) && (count < trig);

endmodule

// File: rtl/rxq_irq_id.sv
module rxq_irq_id
    import uart_rxq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  rxq_cfg_t   cfg,
    input  logic       line_pend,
    input  logic       data_pend,
    input  logic       idle_pend,
    output logic [7:0] iir,
    output logic       irq
);
    irq_src_e src;
    logic     any;

    always_comb begin
        if (line_pend)      src = SRC_LINE;
        else if (data_pend) src = SRC_DATA;
        else if (idle_pend) src = SRC_IDLE;
        else                src = SRC_NONE;
    end

    assign any = line_pend || data_pend || idle_pend;
    assign irq = any;
    assign iir = {cfg.en ? 2'b11 : 2'b00, cfg.en && cfg.wide, 1'b0, src, ~any};

    // R5
    line_first_chk: assert property (@(posedge clk) disable iff (rst)
        line_pend |-> iir[3:1] == 3'b011);

endmodule

// File: rtl/uart_rx_fifo_ctrl.sv
module uart_rx_fifo_ctrl
    import uart_rxq_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        rx_valid,
    input  logic [7:0]  rx_data,
    input  logic        char_tick,
    input  logic        reg_wr,
    input  logic        reg_rd,
    input  logic [2:0]  reg_addr,
    input  logic [7:0]  reg_wdata,
    output logic [7:0]  reg_rdata,
    output logic        irq
);
    rxq_cfg_t         cfg_q, cfg_new;
    logic             ovr_q;
    logic             ctrl_wr, data_rd, stat_rd, flush;
    logic             dropped, idle_pend;
    logic [CNT_W-1:0] count, cap, trig;
    logic [7:0]       head, iir;

    assign cfg_new = '{trig: reg_wdata[7:6], wide: reg_wdata[5], en: reg_wdata[0]};
    assign ctrl_wr = reg_wr && reg_addr == ADDR_CTRL;
    assign data_rd = reg_rd && reg_addr == ADDR_DATA;
    assign stat_rd = reg_rd && reg_addr == ADDR_STAT;
    assign flush   = ctrl_wr && (reg_wdata[1] || cfg_new.wide != cfg_q.wide
                                 || cfg_new.en != cfg_q.en);

    assign cap  = rxq_capacity(cfg_q);
    assign trig = rxq_trigger(cfg_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
            ovr_q <= 1'b0;
        end else begin
            if (ctrl_wr) cfg_q <= cfg_new;
            if (dropped)      ovr_q <= 1'b1;
            else if (stat_rd) ovr_q <= 1'b0;
        end
    end

    rxq_store #(.DEPTH(BIG_DEPTH), .DW(DATA_W)) u_store (
        .clk(clk), .rst(rst), .push(rx_valid), .pop(data_rd), .flush(flush),
        .din(rx_data), .cap(cap), .dout(head), .count(count), .dropped(dropped)
    );

    rxq_idle_timer #(.TICKS(IDLE_CHARS)) u_idle (
        .clk(clk), .rst(rst), .activity(rx_valid || data_rd || flush),
        .tick(char_tick), .count(count), .trig(trig), .pend(idle_pend)
    );

    rxq_irq_id u_id (
        .clk(clk), .rst(rst), .cfg(cfg_q), .line_pend(ovr_q),
        .data_pend(count >= trig), .idle_pend(idle_pend), .iir(iir), .irq(irq)
    );

    always_comb begin
        case (reg_addr)
            ADDR_DATA: reg_rdata = (count != '0) ? head : 8'h00;
            ADDR_CTRL: reg_rdata = iir;
            ADDR_STAT: reg_rdata = {6'b0, ovr_q, count != '0};
            default:   reg_rdata = 8'h00;
        endcase
    end

    // R3
    data_level_chk: assert property (@(posedge clk) disable iff (rst)
        (count >= trig && !ovr_q) |-> iir[3:1] == 3'b010);

    // R6
    idle_range_chk: assert property (@(posedge clk) disable iff (rst)
        idle_pend |-> (count != '0 && count < trig));

    // R10
    irq_flag_chk: assert property (@(posedge clk) disable iff (rst)
        irq == !iir[0]);

endmodule

// File: tb/test_uart_rx_fifo_ctrl.sv
module test_uart_rx_fifo_ctrl;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rx_valid = 1'b0, char_tick = 1'b0, reg_wr = 1'b0, reg_rd = 1'b0;
    logic [7:0] rx_data = '0, reg_wdata = '0;
    logic [2:0] reg_addr = '0;
    logic [7:0] reg_rdata;
    logic       irq;

    int checks = 0, errors = 0;
    bit finished = 0;

    // reference model
    logic [7:0] q[$];
    bit m_ovr = 0, m_en = 0, m_wide = 0;
    logic [1:0] m_sel = 0;
    int m_idle = 0;

    always #5 clk = ~clk;

    uart_rx_fifo_ctrl i_uart_rx_fifo_ctrl (
        .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_data(rx_data),
        .char_tick(char_tick), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
    );

    function automatic int m_cap();
        if (!m_en) return 1;
        return m_wide ? 64 : 16;
    endfunction

    function automatic int m_trig();
        if (!m_en) return 1;
        if (m_wide) begin
            case (m_sel) 2'd0: return 1; 2'd1: return 16; 2'd2: return 32; default: return 56; endcase
        end
        case (m_sel) 2'd0: return 1; 2'd1: return 4; 2'd2: return 8; default: return 14; endcase
    endfunction

    function automatic logic [7:0] m_iir();
        bit rda, tmo, pend;
        logic [2:0] id;
        rda = q.size() >= m_trig();
        tmo = (m_idle == 4) && q.size() > 0 && q.size() < m_trig();
        pend = m_ovr || rda || tmo;
        id = m_ovr ? 3'b011 : rda ? 3'b010 : tmo ? 3'b110 : 3'b000;
        return {m_en ? 2'b11 : 2'b00, m_en && m_wide, 1'b0, id, !pend};
    endfunction

    function automatic logic [7:0] m_read(logic [2:0] a);
        if (a == 3'd0) return q.size() > 0 ? q[0] : 8'h00;
        if (a == 3'd2) return m_iir();
        if (a == 3'd5) return {6'b0, m_ovr, q.size() > 0};
        return 8'h00;
    endfunction

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // one cycle: rd_addr < 0 means no read
    task automatic step(string tag, bit v, logic [7:0] d, bit tick, int rd_addr,
                        bit wr, logic [7:0] wd);
        bit flush, pop, do_rd;
        @(negedge clk);
        do_rd = rd_addr >= 0;
        rx_valid = v; rx_data = d; char_tick = tick;
        reg_rd = do_rd; reg_wr = wr; reg_wdata = wd;
        reg_addr = wr ? 3'd2 : (do_rd ? 3'(rd_addr) : 3'd7);
        #1;
        if (do_rd) check(tag, reg_rdata, m_read(3'(rd_addr)));
        check({tag, " R10 irq"}, irq, !m_iir()[0]);
        flush = wr && (wd[1] || wd[5] != m_wide || wd[0] != m_en);
        pop = do_rd && rd_addr == 0 && q.size() > 0;
        @(posedge clk);
        if (v || (do_rd && rd_addr == 0) || flush || q.size() == 0) m_idle = 0;
        else if (tick && m_idle < 4) m_idle++;
        if (flush) begin
            q.delete();
        end else begin
            if (v && q.size() == m_cap() && !pop) m_ovr = 1;
            else if (do_rd && rd_addr == 5) m_ovr = 0;
            if (pop) void'(q.pop_front());
            if (v && !(q.size() == m_cap() && !pop) && !(pop && q.size() + 1 > m_cap()))
                q.push_back(d);
        end
        if (flush && do_rd && rd_addr == 5) m_ovr = 0;
        if (wr) begin m_en = wd[0]; m_wide = wd[5]; m_sel = wd[7:6]; end
    endtask

    task automatic push(string tag, logic [7:0] d); step(tag, 1, d, 0, -1, 0, 0); endtask
    task automatic rd(string tag, int a);            step(tag, 0, 0, 0, a, 0, 0); endtask
    task automatic wr_ctrl(string tag, logic [7:0] v); step(tag, 0, 0, 0, -1, 1, v); endtask

    initial begin
        #(10 * 150000);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int lvl;
        void'($urandom(32'd4242));
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;

        // reset state
        rd("R4 reset iir", 2);
        check("R4 reset iir value", m_iir(), 8'h01);
        rd("R7 reset status", 5);

        // R1 / R2 trigger tables
        for (int w = 0; w < 2; w++) begin
            for (int s = 0; s < 4; s++) begin
                wr_ctrl("R8 cfg", {2'(s), 1'(w), 3'b000, 1'b1, 1'b1});
                lvl = m_trig();
                for (int k = 0; k < lvl - 1; k++) push("R3 fill", 8'(k + 1));
                rd(w ? "R2 below trigger" : "R1 below trigger", 2);
                push("R3 fill", 8'hA5);
                rd(w ? "R2 at trigger" : "R1 at trigger", 2);
                rd("R3 pop", 0);
                rd("R3 below after read", 2);
            end
        end

        // R6 timeout in 16 mode, trigger 4
        wr_ctrl("R8 cfg", 8'b01_0_000_1_1);
        push("R6", 8'h11); push("R6", 8'h22);
        repeat (3) step("R6 ticks", 0, 0, 1, -1, 0, 0);
        rd("R6 before fourth", 2);
        step("R6 tick", 0, 0, 1, -1, 0, 0);
        rd("R6 timeout shown", 2);
        check("R6 timeout id", m_iir()[3:0], 4'hC);
        rd("R6 read clears", 0);
        rd("R6 cleared", 2);

        // R7 overflow in 64 mode, then R9 order
        wr_ctrl("R8 cfg", 8'b11_1_000_1_1);
        for (int k = 0; k < 65; k++) push("R7 fill", 8'(k * 3 + 7));
        rd("R5 line first", 2);
        rd("R7 overrun flag", 5);
        rd("R7 overrun cleared", 5);
        for (int k = 0; k < 64; k++) rd("R9 order", 0);
        rd("R9 empty read", 0);
        rd("R9 empty status", 5);

        // R8 flush by reset bit
        for (int k = 0; k < 5; k++) push("R8 fill", 8'(k));
        wr_ctrl("R8 flush", 8'b11_1_000_1_1);
        rd("R8 flushed status", 5);

        // R11 non-FIFO mode
        wr_ctrl("R11 cfg", 8'h00);
        push("R11", 8'h5A);
        rd("R11 holding", 2);
        push("R11", 8'h6B);
        rd("R11 overrun iir", 2);
        check("R11 iir value", m_iir(), 8'h06);
        rd("R11 status", 5);
        rd("R11 data", 0);

        // random phase
        for (int ph = 0; ph < 40; ph++) begin
            int pv = (ph % 2 == 0) ? 70 : 20;
            if ($urandom % 3 == 0)
                wr_ctrl("R8 rnd cfg", 8'($urandom) & 8'hE3);
            for (int c = 0; c < 80; c++) begin
                int a = $urandom % 10;
                int ra = (a < 4) ? 0 : (a < 8) ? 2 : (a == 8) ? 5 : -1;
                step("R5 rnd", ($urandom % 100) < pv, 8'($urandom),
                     ($urandom % 3) == 0, ra, 0, 0);
            end
        end

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule